// File: doc/BRIEF.md
# Stuffed-Frame Remote Pin Command Responder

This block serves pin requests that arrive over a byte-oriented serial link from a controlling node. Received bytes are gathered into a frame until a 0x00 delimiter appears. The frame is then unstuffed from its Consistent Overhead Byte Stuffing (COBS) form. The decoded request is checked and acted on: one of up to `NPINS` local pins is either sampled or driven. A short stuffed reply frame is then streamed back to the transmitter.

The byte interfaces face an 8N1 UART receiver and transmitter outside this block. Received bytes arrive as single-cycle strobes, and transmitted bytes leave under a valid/ready handshake. Pins are exposed as a sampled input vector plus output-value and output-enable vectors. Only one request is in flight at a time. Traffic that arrives while a request is being handled is thrown away up to the next delimiter.

Top module: `cobs_pin_responder`

## Requirements
- R1: While reset is asserted, `pin_oe_o` and `pin_o` are all zero (every pin is an input) and `tx_valid_o` is low.
- R2: A 0x00 byte closes a frame. Each overhead byte n stands for n-1 literal bytes followed by an implied 0x00. That implied zero is dropped when n is 0xFF or when the frame ends there, so `04 03 47 45 01` decodes to `03 47 45 00`.
- R3: The decoded frame `03 'G'(0x47) 'E'(0x45) p` with p < NPINS produces the reply `03 'O'(0x4F) 'K'(0x4B) v`, where v is `pin_i[p]` (0 or 1).
- R4: The decoded frame `04 'S'(0x53) 'E'(0x45) p v` with p < NPINS and v equal to 0 or 1 sets `pin_oe_o[p]` to 1 and `pin_o[p]` to v. It produces the reply `02 'O' 'K'`.
- R5: A reply is sent stuffed. Each run is sent as an overhead byte followed by its literal bytes, and the reply ends with exactly one 0x00. For example, `03 4F 4B 00` is sent as `04 03 4F 4B 01 00`.
- R6: A decoded frame whose first byte differs from its remaining byte count gets the reply `02 'N'(0x4E) 'K'`, and no pin changes. The same applies to an unknown opcode, a pin index of NPINS or more, and a write level above 1.
- R7: A frame in which an overhead byte points past the frame end gets the reply `02 'N' 'K'`.
- R8: A frame of more than 16 stuffed bytes gets the reply `02 'N' 'K'`.
- R9: A frame with no bytes before its delimiter produces no reply.
- R10: Bytes that arrive while a request is being decoded, executed or answered are discarded, together with the rest of their frame up to its delimiter. They produce no reply and no pin change.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Single-cycle strobe marking `rx_data_i` |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| tx_valid_o | output | 1 | `tx_data_o` is valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |
| pin_i | input | NPINS | Sampled pin levels |
| pin_o | output | NPINS | Driven pin levels |
| pin_oe_o | output | NPINS | Per-pin output enable, 1 = driven |

## Verification
The hardest case to reach is R10: a complete request that lands while an earlier reply is still pending. The bench reaches it by holding `tx_ready_i` low. This freezes the first reply at its first byte, and a write request is sent during that stall. Once the stall is released, the bench checks three things: only the first reply appears, the targeted pin's enable is unchanged, and a later read is answered normally. The overhead-past-end, oversize and implied-trailing-zero frames are hand-stuffed byte sequences, so the decoder's edge paths are reached directly.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int RAW_MAX   = 16;
  localparam int RAW_IW    = $clog2(RAW_MAX);
  localparam int LEN_W     = $clog2(RAW_MAX + 1);
  localparam int REPLY_MAX = 4;
  localparam int RL_W      = $clog2(REPLY_MAX + 1);
  localparam int ENC_MAX   = REPLY_MAX + 2;
  localparam int ENC_W     = $clog2(ENC_MAX + 1);

  localparam logic [7:0] CH_G = 8'h47;
  localparam logic [7:0] CH_E = 8'h45;
  localparam logic [7:0] CH_S = 8'h53;
  localparam logic [7:0] CH_O = 8'h4F;
  localparam logic [7:0] CH_K = 8'h4B;
  localparam logic [7:0] CH_N = 8'h4E;

  typedef logic [RAW_MAX-1:0][7:0]   raw_arr_t;
  typedef logic [REPLY_MAX-1:0][7:0] reply_arr_t;
  typedef logic [ENC_MAX-1:0][7:0]   enc_arr_t;

  typedef struct packed {
    raw_arr_t         data;
    logic [LEN_W-1:0] len;
    logic             err;
  } dec_t;

  typedef struct packed {
    enc_arr_t         data;
    logic [ENC_W-1:0] len;
  } enc_t;

  function automatic dec_t cobs_decode(raw_arr_t raw, logic [LEN_W-1:0] n);
    dec_t r;
    logic [7:0] left, code;
    logic [LEN_W-1:0] o;
    r    = '0;
    left = 8'd0;
    code = 8'hFF;  // no implied zero ahead of the first block
    o    = '0;
    for (int k = 0; k < RAW_MAX; k++) begin
      if (LEN_W'(k) < n) begin
        if (left == 8'd0) begin
          if (code != 8'hFF) begin
            r.data[o[RAW_IW-1:0]] = 8'h00;
            o = o + 1'b1;
          end
          code = raw[k];
          left = code - 8'd1;
          if (code == 8'h00) r.err = 1'b1;
        end else begin
          r.data[o[RAW_IW-1:0]] = raw[k];
          o    = o + 1'b1;
          left = left - 8'd1;
        end
      end
    end
    if (left != 8'd0) r.err = 1'b1;
    r.len = o;
    return r;
  endfunction

  // replies are far shorter than 254 bytes, so no 0xFF run split is needed
  function automatic enc_t cobs_encode(reply_arr_t p, logic [RL_W-1:0] n);
    enc_t r;
    logic [ENC_W-1:0] ci, wo;
    logic [7:0] code;
    r    = '0;
    ci   = '0;
    wo   = ENC_W'(1);
    code = 8'd1;
    for (int i = 0; i < REPLY_MAX; i++) begin
      if (RL_W'(i) < n) begin
        if (p[i] == 8'h00) begin
          r.data[ci] = code;
          ci   = wo;
          wo   = wo + 1'b1;
          code = 8'd1;
        end else begin
          r.data[wo] = p[i];
          wo   = wo + 1'b1;
          code = code + 8'd1;
        end
      end
    end
    r.data[ci] = code;
    r.data[wo] = 8'h00;
    r.len      = wo + 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/cpr_rx_collect.sv
module cpr_rx_collect
  import cpr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  input  logic             busy_i,
  output logic             frame_valid_o,
  output raw_arr_t         frame_o,
  output logic [LEN_W-1:0] frame_len_o,
  output logic             frame_ovf_o
);
  raw_arr_t         buf_q;
  logic [LEN_W-1:0] cnt_q, frame_len_q;
  logic             ovf_q, skip_q, frame_valid_q, frame_ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q         <= '0;
      cnt_q         <= '0;
      ovf_q         <= 1'b0;
      skip_q        <= 1'b0;
      frame_valid_q <= 1'b0;
      frame_len_q   <= '0;
      frame_ovf_q   <= 1'b0;
    end else begin
      frame_valid_q <= 1'b0;
      if (rx_valid_i) begin
        if (rx_data_i == 8'h00) begin
          if (!busy_i && !skip_q && (cnt_q != '0 || ovf_q)) begin
            frame_valid_q <= 1'b1;
            frame_len_q   <= cnt_q;
            frame_ovf_q   <= ovf_q;
          end
          skip_q <= 1'b0;
          cnt_q  <= '0;
          ovf_q  <= 1'b0;
        end else if (busy_i || skip_q) begin
          skip_q <= 1'b1;
          cnt_q  <= '0;
          ovf_q  <= 1'b0;
        end else if (cnt_q == LEN_W'(RAW_MAX)) begin
          ovf_q <= 1'b1;
        end else begin
          buf_q[cnt_q[RAW_IW-1:0]] <= rx_data_i;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign frame_valid_o = frame_valid_q;
  assign frame_o       = buf_q;
  assign frame_len_o   = frame_len_q;
  assign frame_ovf_o   = frame_ovf_q;

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LEN_W'(RAW_MAX));

  a_r9_no_empty_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_q |-> (frame_len_q != '0 || frame_ovf_q));
endmodule

// File: rtl/cpr_cmd_exec.sv
module cpr_cmd_exec
  import cpr_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_valid_i,
  input  raw_arr_t         frame_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             frame_ovf_i,
  input  logic [NPINS-1:0] pin_i,
  output logic             reply_valid_o,
  output reply_arr_t       reply_o,
  output logic [RL_W-1:0]  reply_len_o,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o
);
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  dec_t             dec;
  logic             bad, idx_ok, is_get, is_set;
  logic [PIN_W-1:0] idx;

  always_comb begin
    dec    = cobs_decode(frame_i, frame_len_i);
    bad    = dec.err || frame_ovf_i || dec.len == '0 ||
             dec.data[0] != 8'(dec.len - 1'b1);
    idx_ok = int'(dec.data[3]) < NPINS;
    idx    = dec.data[3][PIN_W-1:0];
    is_get = !bad && dec.data[0] == 8'd3 && dec.data[1] == CH_G &&
             dec.data[2] == CH_E && idx_ok;
    is_set = !bad && dec.data[0] == 8'd4 && dec.data[1] == CH_S &&
             dec.data[2] == CH_E && idx_ok && dec.data[4] <= 8'd1;
  end

  logic             reply_valid_q;
  reply_arr_t       reply_q;
  logic [RL_W-1:0]  reply_len_q;
  logic [NPINS-1:0] pin_q, pin_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reply_valid_q <= 1'b0;
      reply_q       <= '0;
      reply_len_q   <= '0;
      pin_q         <= '0;
      pin_oe_q      <= '0;
    end else begin
      reply_valid_q <= frame_valid_i;
      if (frame_valid_i) begin
        if (is_get) begin
          reply_q     <= {7'd0, pin_i[idx], CH_K, CH_O, 8'd3};
          reply_len_q <= RL_W'(4);
        end else if (is_set) begin
          pin_oe_q[idx] <= 1'b1;
          pin_q[idx]    <= dec.data[4][0];
          reply_q       <= {8'd0, CH_K, CH_O, 8'd2};
          reply_len_q   <= RL_W'(3);
        end else begin
          reply_q     <= {8'd0, CH_K, CH_N, 8'd2};
          reply_len_q <= RL_W'(3);
        end
      end
    end
  end

  assign reply_valid_o = reply_valid_q;
  assign reply_o       = reply_q;
  assign reply_len_o   = reply_len_q;
  assign pin_o         = pin_q;
  assign pin_oe_o      = pin_oe_q;

  a_r6_pins_move_only_on_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(pin_oe_q) && $stable(pin_q)) |-> reply_valid_q && reply_q[1] == CH_O);

  a_r3_reply_tail_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_valid_q |-> reply_q[2] == CH_K);
endmodule

// File: rtl/cpr_tx_encode.sv
module cpr_tx_encode
  import cpr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reply_valid_i,
  input  reply_arr_t      reply_i,
  input  logic [RL_W-1:0] reply_len_i,
  input  logic            tx_ready_i,
  output logic [7:0]      tx_data_o,
  output logic            tx_valid_o,
  output logic            busy_o
);
  enc_t             enc;
  enc_arr_t         enc_q;
  logic [ENC_W-1:0] len_q, pos_q;
  logic             active_q;

  always_comb enc = cobs_encode(reply_i, reply_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_q    <= '0;
      len_q    <= '0;
      pos_q    <= '0;
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (reply_valid_i) begin
        enc_q    <= enc.data;
        len_q    <= enc.len;
        pos_q    <= '0;
        active_q <= 1'b1;
      end
    end else if (tx_ready_i) begin
      if (pos_q == len_q - 1'b1) active_q <= 1'b0;
      else                       pos_q    <= pos_q + 1'b1;
    end
  end

  assign tx_data_o  = enc_q[pos_q];
  assign tx_valid_o = active_q;
  assign busy_o     = active_q;

  a_r11_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r5_delim_ends_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_data_o == 8'h00 |=> !tx_valid_o);

  a_r10_no_load_while_sending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_valid_i |-> !active_q);
endmodule

// File: rtl/cobs_pin_responder.sv
module cobs_pin_responder
  import cpr_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o
);
  logic             frame_valid, frame_ovf, reply_valid, tx_busy, busy;
  raw_arr_t         frame;
  logic [LEN_W-1:0] frame_len;
  reply_arr_t       reply;
  logic [RL_W-1:0]  reply_len;

  // one request in flight: held from delimiter until the reply's last byte
  assign busy = frame_valid | reply_valid | tx_busy;

  cpr_rx_collect i_rx (
    .clk_i, .rst_ni, .rx_data_i, .rx_valid_i,
    .busy_i        (busy),
    .frame_valid_o (frame_valid),
    .frame_o       (frame),
    .frame_len_o   (frame_len),
    .frame_ovf_o   (frame_ovf)
  );

  cpr_cmd_exec #(.NPINS(NPINS)) i_exec (
    .clk_i, .rst_ni,
    .frame_valid_i (frame_valid),
    .frame_i       (frame),
    .frame_len_i   (frame_len),
    .frame_ovf_i   (frame_ovf),
    .pin_i,
    .reply_valid_o (reply_valid),
    .reply_o       (reply),
    .reply_len_o   (reply_len),
    .pin_o, .pin_oe_o
  );

  cpr_tx_encode i_tx (
    .clk_i, .rst_ni,
    .reply_valid_i (reply_valid),
    .reply_i       (reply),
    .reply_len_i   (reply_len),
    .tx_ready_i, .tx_data_o, .tx_valid_o,
    .busy_o        (tx_busy)
  );
endmodule

// File: tb/test_cobs_pin_responder.sv
module test_cobs_pin_responder;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0, tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic tx_valid;
  logic [NPINS-1:0] pin_i = 32'h8000_0081, pin_o, pin_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rq[$];
  logic [7:0] eq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cobs_pin_responder #(.NPINS(NPINS)) i_cobs_pin_responder (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_rq();
    foreach (rq[i]) begin
      @(posedge clk); #1;
      rx_data = rq[i]; rx_valid = 1'b1;
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic expect_eq(input string tag);
    foreach (eq[i]) begin
      exp_q.push_back(eq[i]);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected reply byte", {56'd0, tx_data}, 64'hFFFF);
      end else begin
        chk(tag_q.pop_front(), {56'd0, tx_data}, {56'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk("R1 oe", {32'd0, pin_oe}, 64'd0);
    chk("R1 out", {32'd0, pin_o}, 64'd0);
    chk("R1 txv", {63'd0, tx_valid}, 64'd0);
    rst_n = 1'b1;

    // R3 read pin 7 (high)
    expect_eq("R3"); // placeholder-free: eq set below before use
    eq = {8'h05, 8'h03, 8'h4F, 8'h4B, 8'h01, 8'h00};
    exp_q.delete(); tag_q.delete();
    expect_eq("R3");
    rq = {8'h05, 8'h03, 8'h47, 8'h45, 8'h07, 8'h00}; send_rq(); drain();

    // R2 pin 0: trailing implied zero
    expect_eq("R2");
    rq = {8'h04, 8'h03, 8'h47, 8'h45, 8'h01, 8'h00}; send_rq(); drain();

    // R5 read low level: reply contains a zero
    eq = {8'h04, 8'h03, 8'h4F, 8'h4B, 8'h01, 8'h00}; expect_eq("R5");
    rq = {8'h05, 8'h03, 8'h47, 8'h45, 8'h04, 8'h00}; send_rq(); drain();

    // R3 top pin with a toggling ready (R11 ordering)
    eq = {8'h05, 8'h03, 8'h4F, 8'h4B, 8'h01, 8'h00}; expect_eq("R3 pin31 R11");
    rq = {8'h05, 8'h03, 8'h47, 8'h45, 8'h1F, 8'h00};
    fork
      send_rq();
      for (int i = 0; i < 30; i++) begin @(posedge clk); #1; tx_ready = ~tx_ready; end
    join
    @(posedge clk); #1; tx_ready = 1'b1;
    drain();

    // R4 writes
    eq = {8'h04, 8'h02, 8'h4F, 8'h4B, 8'h00}; expect_eq("R4");
    rq = {8'h06, 8'h04, 8'h53, 8'h45, 8'h05, 8'h01, 8'h00}; send_rq(); drain();
    expect_eq("R4");
    rq = {8'h05, 8'h04, 8'h53, 8'h45, 8'h09, 8'h01, 8'h00}; send_rq(); drain();
    chk("R4 oe", {32'd0, pin_oe}, 64'h220);
    chk("R4 out", {32'd0, pin_o}, 64'h20);

    // R6 rejects
    eq = {8'h04, 8'h02, 8'h4E, 8'h4B, 8'h00};
    expect_eq("R6 pin32");
    rq = {8'h05, 8'h03, 8'h47, 8'h45, 8'h20, 8'h00}; send_rq(); drain();
    expect_eq("R6 length");
    rq = {8'h05, 8'h02, 8'h47, 8'h45, 8'h07, 8'h00}; send_rq(); drain();
    expect_eq("R6 opcode");
    rq = {8'h05, 8'h03, 8'h58, 8'h59, 8'h07, 8'h00}; send_rq(); drain();
    expect_eq("R6 level");
    rq = {8'h06, 8'h04, 8'h53, 8'h45, 8'h0A, 8'h02, 8'h00}; send_rq(); drain();
    chk("R6 oe unchanged", {32'd0, pin_oe}, 64'h220);

    // R7 overhead points past end
    expect_eq("R7");
    rq = {8'h05, 8'h03, 8'h47, 8'h45, 8'h00}; send_rq(); drain();

    // R8 oversize
    expect_eq("R8");
    rq.delete();
    for (int i = 0; i < 17; i++) rq.push_back(8'h01);
    rq.push_back(8'h00);
    send_rq(); drain();

    // R9 empty frame
    rq = {8'h00}; send_rq();
    repeat (20) @(posedge clk);
    #1 chk("R9 no reply", {63'd0, tx_valid}, 64'd0);

    // R10 / R11: request while reply is stalled
    @(posedge clk); #1; tx_ready = 1'b0;
    eq = {8'h05, 8'h03, 8'h4F, 8'h4B, 8'h01, 8'h00}; expect_eq("R10 first");
    rq = {8'h05, 8'h03, 8'h47, 8'h45, 8'h07, 8'h00}; send_rq();
    rq = {8'h06, 8'h04, 8'h53, 8'h45, 8'h0C, 8'h01, 8'h00}; send_rq();
    repeat (5) @(posedge clk);
    #1;
    chk("R11 valid held", {63'd0, tx_valid}, 64'd1);
    chk("R11 data held", {56'd0, tx_data}, 64'h05);
    tx_ready = 1'b1;
    drain();
    chk("R10 oe unchanged", {32'd0, pin_oe}, 64'h220);
    eq = {8'h04, 8'h03, 8'h4F, 8'h4B, 8'h01, 8'h00}; expect_eq("R10 recovery");
    rq = {8'h05, 8'h03, 8'h47, 8'h45, 8'h0C, 8'h00}; send_rq(); drain();

    chk("R5 all replies seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule